// File: doc/BRIEF.md
# Shared CAN Message Buffer RAM

This block is the storage that a CPU and a CAN controller share for frames in flight. It holds fifteen message buffers of eight 16-bit words each, followed by one reserved bank, in a 128-word address space. Each buffer holds a status/control word, a timestamp, four payload words and two identifier words. Both sides reach the storage through their own request ports, and either side can read or write a whole word or a single byte lane.

Only one access reaches the storage in a clock cycle. When both ports ask in the same cycle, the CAN port is served and the CPU port is held by a combinational ready signal until a cycle comes with no CAN request. The CAN side marks a buffer busy while it copies a received frame into it or while the buffer is queued for transmission. While a buffer is busy, the CPU cannot change its payload, timestamp, identifiers or length code. The CPU can still write the priority and status byte, and it can still read every word.

Top module: `can_msgbuf_ram`

## Requirements
- R1: Word address bits 6:3 select the bank and bits 2:0 select the word in it. Banks 0 to 14 are buffers. Word 0 is status/control, with the length code in 15:12, reserved bits in 11:8, priority in 7:4 and status in 3:0. Word 1 is the timestamp, words 2 to 5 are payload, and words 6 and 7 are the identifiers. Read data of a granted read appears on the port's rdata in the cycle after the grant edge and holds until that port's next granted read.
- R2: Byte enable bit 1 writes bits 15:8 and bit 0 writes bits 7:0. A lane whose enable is low keeps its old contents. This applies on both ports.
- R3: When can_req is high, cpu_rdy is low and the CPU access is not performed. A held CPU access is performed, without loss, at the first edge where can_req is low.
- R4: With can_req low, cpu_rdy is high, so a CPU access finishes in a single cycle.
- R5: A CPU write to words 1 to 7 of a busy buffer completes its handshake but leaves the word unchanged.
- R6: A CPU write to word 0 of a busy buffer updates the low byte (priority and status) if enabled, and leaves the high byte (length code) unchanged.
- R7: CPU reads of a busy buffer return the stored contents.
- R8: CAN port writes are never blocked by a busy flag.
- R9: busy_set marks buffer busy_set_idx busy, and busy_clr clears buffer busy_clr_idx. Both take effect from the next edge. If both target the same buffer in one cycle, set wins. An index of 15 changes no flag.
- R10: Bank 15 reads as zero on both ports and ignores writes from both ports.
- R11: Bits 11:8 of every status/control word always read as zero.
- R12: After reset, both rdata outputs are zero and no buffer is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_be | input | 2 | CPU byte lane enables, bit 1 is the upper lane |
| cpu_addr | input | 7 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdy | output | 1 | CPU access is taken at this edge |
| cpu_rdata | output | 16 | CPU read data |
| can_req | input | 1 | CAN access request, always served |
| can_we | input | 1 | CAN write (1) or read (0) |
| can_be | input | 2 | CAN byte lane enables |
| can_addr | input | 7 | CAN word address |
| can_wdata | input | 16 | CAN write data |
| can_rdata | output | 16 | CAN read data |
| busy_set | input | 1 | Mark a buffer busy |
| busy_set_idx | input | 4 | Buffer to mark busy |
| busy_clr | input | 1 | Clear a buffer's busy flag |
| busy_clr_idx | input | 4 | Buffer to clear |

## Verification
The bench targets a CPU write and a CAN write that collide on the same word. A design that lost the held CPU write, or that let the CPU win, would leave the CAN value in place. It checks the status/control word of a busy buffer lane by lane: blocking the whole word would lose a status update, and allowing the whole word would corrupt the length code. It sets and clears the same buffer in one cycle, and issues a set with index 15, which a design that truncated the index would apply to buffer 7. Random mixed traffic from both ports, with busy flags toggling, also checks that reserved bits and the reserved bank always read zero.

// File: rtl/can_msgbuf_pkg.sv
package can_msgbuf_pkg;

    localparam int unsigned MB_COUNT  = 15;
    localparam int unsigned MB_WORDS  = 8;
    localparam int unsigned MB_DW     = 16;
    localparam int unsigned MB_LANES  = MB_DW / 8;
    localparam int unsigned MB_BANKS  = MB_COUNT + 1;
    localparam int unsigned MB_OFF_W  = $clog2(MB_WORDS);
    localparam int unsigned MB_BANK_W = $clog2(MB_BANKS);
    localparam int unsigned MB_AW     = MB_OFF_W + MB_BANK_W;
    localparam int unsigned MB_LIVE   = MB_COUNT * MB_WORDS;

    localparam logic [MB_OFF_W-1:0]  OFF_CTRL   = '0;
    localparam logic [MB_BANK_W-1:0] BANK_RESV  = MB_BANK_W'(MB_COUNT);
    localparam logic [MB_DW-1:0]     CTRL_GAP   = 16'h0F00;

    typedef struct packed {
        logic                we;
        logic [MB_LANES-1:0] be;
        logic [MB_AW-1:0]    addr;
        logic [MB_DW-1:0]    wdata;
    } mb_access_t;

    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_CAN  = 2'd1,
        PORT_CPU  = 2'd2
    } mb_port_e;

    function automatic logic [MB_BANK_W-1:0] bank_of(input logic [MB_AW-1:0] a);
        return a[MB_AW-1:MB_OFF_W];
    endfunction

    function automatic logic [MB_OFF_W-1:0] off_of(input logic [MB_AW-1:0] a);
        return a[MB_OFF_W-1:0];
    endfunction

    function automatic logic in_resv(input logic [MB_AW-1:0] a);
        return bank_of(a) == BANK_RESV;
    endfunction

endpackage

// File: rtl/msgbuf_arbiter.sv
module msgbuf_arbiter
    import can_msgbuf_pkg::*;
(
    input  logic     cpu_req,
    input  logic     can_req,
    output logic     cpu_rdy,
    output mb_port_e winner
);
    // Fixed priority: the CAN side never waits.
    always_comb begin
        cpu_rdy = !can_req;
        if (can_req)      winner = PORT_CAN;
        else if (cpu_req) winner = PORT_CPU;
        else              winner = PORT_IDLE;
    end
endmodule

// File: rtl/msgbuf_busy.sv
module msgbuf_busy
    import can_msgbuf_pkg::*;
#(
    parameter int unsigned N     = MB_COUNT,
    parameter int unsigned IDX_W = MB_BANK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     busy
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                                      busy[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))      busy[i] <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(i))      busy[i] <= 1'b0;
        end
    end

    assert_set_marks_R9: assert property (@(posedge clk) disable iff (rst)
        (set_en && set_idx < IDX_W'(N)) |=> busy[$past(set_idx)]);

    assert_clr_releases_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_en && clr_idx < IDX_W'(N) && !(set_en && set_idx == clr_idx))
        |=> !busy[$past(clr_idx)]);
endmodule

// File: rtl/msgbuf_guard.sv
module msgbuf_guard
    import can_msgbuf_pkg::*;
#(
    parameter bit HONOUR_BUSY = 1'b1
) (
    input  logic                we,
    input  logic [MB_LANES-1:0] be,
    input  logic [MB_AW-1:0]    addr,
    input  logic [MB_BANKS-1:0] busy_ext,
    output logic [MB_LANES-1:0] be_eff
);
    logic [MB_LANES-1:0] ctrl_open;
    assign ctrl_open = MB_LANES'(1);  // only the priority/status lane

    if (HONOUR_BUSY) begin : g_guarded
        always_comb begin
            if (!we || in_resv(addr))            be_eff = '0;
            else if (!busy_ext[bank_of(addr)])   be_eff = be;
            else if (off_of(addr) == OFF_CTRL)   be_eff = be & ctrl_open;
            else                                 be_eff = '0;
        end
    end else begin : g_open
        logic unused_busy;
        assign unused_busy = ^busy_ext;
        always_comb begin
            if (!we || in_resv(addr)) be_eff = '0;
            else                      be_eff = be;
        end
    end
endmodule

// File: rtl/msgbuf_storage.sv
module msgbuf_storage
    import can_msgbuf_pkg::*;
#(
    parameter int unsigned DEPTH = MB_LIVE
) (
    input  logic                clk,
    input  logic [MB_LANES-1:0] wr_be,
    input  logic [MB_AW-1:0]    addr,
    input  logic [MB_DW-1:0]    wdata,
    output logic [MB_DW-1:0]    rd_word
);
    logic [MB_DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < int'(MB_LANES); l++) begin
            if (wr_be[l]) mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
        end
    end

    always_comb begin
        if (in_resv(addr))                 rd_word = '0;
        else if (off_of(addr) == OFF_CTRL) rd_word = mem[addr] & ~CTRL_GAP;
        else                               rd_word = mem[addr];
    end
endmodule

// File: rtl/can_msgbuf_ram.sv
module can_msgbuf_ram
    import can_msgbuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [1:0]           cpu_be,
    input  logic [6:0]           cpu_addr,
    input  logic [15:0]          cpu_wdata,
    output logic                 cpu_rdy,
    output logic [15:0]          cpu_rdata,
    input  logic                 can_req,
    input  logic                 can_we,
    input  logic [1:0]           can_be,
    input  logic [6:0]           can_addr,
    input  logic [15:0]          can_wdata,
    output logic [15:0]          can_rdata,
    input  logic                 busy_set,
    input  logic [3:0]           busy_set_idx,
    input  logic                 busy_clr,
    input  logic [3:0]           busy_clr_idx
);
    mb_access_t          cpu_acc, can_acc, sel_acc;
    mb_port_e            winner;
    logic [MB_COUNT-1:0] busy;
    logic [MB_BANKS-1:0] busy_ext;
    logic [MB_LANES-1:0] cpu_be_eff, can_be_eff, sel_be;
    logic [MB_DW-1:0]    rd_word;

    assign cpu_acc  = '{we: cpu_we, be: cpu_be, addr: cpu_addr, wdata: cpu_wdata};
    assign can_acc  = '{we: can_we, be: can_be, addr: can_addr, wdata: can_wdata};
    assign busy_ext = {1'b0, busy};

    msgbuf_arbiter i_arb (
        .cpu_req (cpu_req),
        .can_req (can_req),
        .cpu_rdy (cpu_rdy),
        .winner  (winner)
    );

    msgbuf_busy #(.N(MB_COUNT), .IDX_W(MB_BANK_W)) i_busy (
        .clk     (clk),
        .rst     (rst),
        .set_en  (busy_set),
        .set_idx (busy_set_idx),
        .clr_en  (busy_clr),
        .clr_idx (busy_clr_idx),
        .busy    (busy)
    );

    msgbuf_guard #(.HONOUR_BUSY(1'b1)) i_cpu_guard (
        .we       (cpu_acc.we),
        .be       (cpu_acc.be),
        .addr     (cpu_acc.addr),
        .busy_ext (busy_ext),
        .be_eff   (cpu_be_eff)
    );

    msgbuf_guard #(.HONOUR_BUSY(1'b0)) i_can_guard (
        .we       (can_acc.we),
        .be       (can_acc.be),
        .addr     (can_acc.addr),
        .busy_ext (busy_ext),
        .be_eff   (can_be_eff)
    );

    always_comb begin
        unique case (winner)
            PORT_CAN: begin sel_acc = can_acc; sel_be = can_be_eff; end
            PORT_CPU: begin sel_acc = cpu_acc; sel_be = cpu_be_eff; end
            default:  begin sel_acc = cpu_acc; sel_be = '0;         end
        endcase
    end

    msgbuf_storage #(.DEPTH(MB_LIVE)) i_store (
        .clk     (clk),
        .wr_be   (sel_be),
        .addr    (sel_acc.addr),
        .wdata   (sel_acc.wdata),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
            can_rdata <= '0;
        end else begin
            if (winner == PORT_CAN && !can_we) can_rdata <= rd_word;
            if (winner == PORT_CPU && !cpu_we) cpu_rdata <= rd_word;
        end
    end

    // Tracking of the last CPU read, used by the checks below.
    logic             chk_rd_q;
    logic [MB_AW-1:0] chk_addr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_rd_q   <= 1'b0;
            chk_addr_q <= '0;
        end else begin
            chk_rd_q   <= (winner == PORT_CPU) && !cpu_we;
            chk_addr_q <= cpu_addr;
        end
    end

    assert_resv_bank_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (chk_rd_q && in_resv(chk_addr_q)) |-> cpu_rdata == '0);

    assert_ctrl_gap_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (chk_rd_q && off_of(chk_addr_q) == OFF_CTRL) |-> (cpu_rdata & CTRL_GAP) == '0);

    assert_busy_payload_shut_R5: assert property (@(posedge clk) disable iff (rst)
        (winner == PORT_CPU && cpu_we && !in_resv(cpu_addr) &&
         busy_ext[bank_of(cpu_addr)] && off_of(cpu_addr) != OFF_CTRL) |-> sel_be == '0);

    assert_busy_ctrl_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (winner == PORT_CPU && cpu_we && !in_resv(cpu_addr) &&
         busy_ext[bank_of(cpu_addr)] && off_of(cpu_addr) == OFF_CTRL)
        |-> sel_be == {1'b0, cpu_be[0]});

    assert_can_write_open_R8: assert property (@(posedge clk) disable iff (rst)
        (can_req && can_we && !in_resv(can_addr)) |-> sel_be == can_be);

    assert_cpu_held_R3: assert property (@(posedge clk) disable iff (rst)
        (can_req && cpu_req) |-> sel_acc.addr == can_addr);
endmodule

// File: tb/test_can_msgbuf_ram.sv
module test_can_msgbuf_ram;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req, cpu_we, can_req, can_we;
    logic [1:0]  cpu_be, can_be;
    logic [6:0]  cpu_addr, can_addr;
    logic [15:0] cpu_wdata, can_wdata, cpu_rdata, can_rdata;
    logic        cpu_rdy;
    logic        busy_set, busy_clr;
    logic [3:0]  busy_set_idx, busy_clr_idx;

    always #2 clk = ~clk;

    can_msgbuf_ram i_can_msgbuf_ram (.*);

    int          total = 0, bad = 0;
    bit          finished = 0;
    logic [15:0] model [128];
    logic [14:0] mbusy;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [6:0] a);
        logic [15:0] v;
        if (a[6:3] == 4'd15) return 16'h0;
        v = model[a];
        if (a[2:0] == 3'd0) v[11:8] = 4'h0;
        return v;
    endfunction

    function automatic string read_tag(input logic [6:0] a);
        if (a[6:3] == 4'd15)              return "R10";
        if (a[2:0] == 3'd0)               return "R11";
        if (mbusy[a[6:3]])                return "R7";
        return "R1";
    endfunction

    function automatic void model_write(input bit from_cpu, input logic [1:0] be,
                                        input logic [6:0] a, input logic [15:0] d);
        logic [1:0] e;
        e = be;
        if (a[6:3] == 4'd15) return;
        if (from_cpu && mbusy[a[6:3]]) e = (a[2:0] == 3'd0) ? (be & 2'b01) : 2'b00;
        if (e[1]) model[a][15:8] = d[15:8];
        if (e[0]) model[a][7:0]  = d[7:0];
    endfunction

    task automatic cpu_op(input bit we, input logic [1:0] be, input logic [6:0] a,
                          input logic [15:0] d, output logic [15:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = d;
        #1;
        while (!cpu_rdy) begin @(negedge clk); #1; end
        @(posedge clk);
        if (we) model_write(1, be, a, d);
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        rd = cpu_rdata;
    endtask

    task automatic can_op(input bit we, input logic [1:0] be, input logic [6:0] a,
                          input logic [15:0] d, output logic [15:0] rd);
        @(negedge clk);
        can_req = 1; can_we = we; can_be = be; can_addr = a; can_wdata = d;
        @(posedge clk);
        if (we) model_write(0, be, a, d);
        @(negedge clk);
        can_req = 0; can_we = 0;
        rd = can_rdata;
    endtask

    task automatic busy_op(input bit se, input logic [3:0] si, input bit ce, input logic [3:0] ci);
        @(negedge clk);
        busy_set = se; busy_set_idx = si; busy_clr = ce; busy_clr_idx = ci;
        @(posedge clk);
        for (int i = 0; i < 15; i++) begin
            if (se && si == 4'(i))      mbusy[i] = 1'b1;
            else if (ce && ci == 4'(i)) mbusy[i] = 1'b0;
        end
        @(negedge clk);
        busy_set = 0; busy_clr = 0;
    endtask

    task automatic cpu_check(input logic [6:0] a, input string tag);
        logic [15:0] rd;
        cpu_op(0, 2'b11, a, 16'h0, rd);
        check(rd == exp_read(a), tag, rd, exp_read(a));
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R3 watchdog actual=hung expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] rd;
        void'($urandom(32'd2718));
        rst = 1; cpu_req = 0; cpu_we = 0; cpu_be = 0; cpu_addr = 0; cpu_wdata = 0;
        can_req = 0; can_we = 0; can_be = 0; can_addr = 0; can_wdata = 0;
        busy_set = 0; busy_clr = 0; busy_set_idx = 0; busy_clr_idx = 0;
        mbusy = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R12 reset state
        check(cpu_rdata == 16'h0, "R12", cpu_rdata, 16'h0);
        check(can_rdata == 16'h0, "R12", can_rdata, 16'h0);
        #1 check(cpu_rdy == 1'b1, "R4", {15'h0, cpu_rdy}, 16'h1);

        // fill every live word through the CAN port
        for (int a = 0; a < 120; a++) can_op(1, 2'b11, 7'(a), 16'(a * 16'h0101 + 16'h3C5A), rd);
        // R12: no buffer busy after reset, so a CPU payload write lands
        cpu_op(1, 2'b11, 7'd18, 16'hBEEF, rd);
        cpu_check(7'd18, "R12");

        // R2 byte lanes
        cpu_op(1, 2'b11, 7'd10, 16'h1234, rd);
        cpu_op(1, 2'b10, 7'd10, 16'hABCD, rd);
        cpu_check(7'd10, "R2");
        can_op(1, 2'b01, 7'd10, 16'h99EF, rd);
        cpu_check(7'd10, "R2");

        // R3 contention: CAN and CPU write the same word
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_be = 2'b11; cpu_addr = 7'd9; cpu_wdata = 16'h1111;
        can_req = 1; can_we = 1; can_be = 2'b11; can_addr = 7'd9; can_wdata = 16'h2222;
        #1 check(cpu_rdy == 1'b0, "R3", {15'h0, cpu_rdy}, 16'h0);
        @(negedge clk);
        can_we = 0;
        #1 check(cpu_rdy == 1'b0, "R3", {15'h0, cpu_rdy}, 16'h0);
        @(negedge clk);
        can_req = 0;
        check(can_rdata == 16'h2222, "R3", can_rdata, 16'h2222);
        #1 check(cpu_rdy == 1'b1, "R4", {15'h0, cpu_rdy}, 16'h1);
        @(posedge clk);
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        model[9] = 16'h1111;
        cpu_check(7'd9, "R3");

        // R5 / R6 / R7 / R8 with buffer 2 busy
        busy_op(1, 4'd2, 0, 4'd0);
        cpu_op(1, 2'b11, 7'd19, 16'hDEAD, rd);
        cpu_check(7'd19, "R5");
        cpu_check(7'd22, "R7");
        cpu_op(1, 2'b11, 7'd16, 16'hF0A5, rd);
        cpu_op(0, 2'b11, 7'd16, 16'h0, rd);
        check(rd[15:12] == model[16][15:12] && rd[7:0] == 8'hA5, "R6", rd, exp_read(7'd16));
        can_op(1, 2'b11, 7'd19, 16'h7777, rd);
        cpu_check(7'd19, "R8");

        // R9 set wins on same index, then clear, then index 15
        busy_op(1, 4'd2, 1, 4'd2);
        cpu_op(1, 2'b11, 7'd20, 16'h5151, rd);
        cpu_check(7'd20, "R9");
        busy_op(0, 4'd0, 1, 4'd2);
        cpu_op(1, 2'b11, 7'd20, 16'h6262, rd);
        check(model[20] == 16'h6262, "R9", model[20], 16'h6262);
        cpu_check(7'd20, "R9");
        busy_op(1, 4'd15, 0, 4'd0);
        cpu_op(1, 2'b11, 7'd59, 16'h4A4A, rd);
        cpu_check(7'd59, "R9");

        // R10 reserved bank
        cpu_op(1, 2'b11, 7'd123, 16'hFFFF, rd);
        can_op(1, 2'b11, 7'd124, 16'hFFFF, rd);
        cpu_check(7'd123, "R10");
        can_op(0, 2'b11, 7'd124, 16'h0, rd);
        check(rd == 16'h0, "R10", rd, 16'h0);

        // R11 reserved bits
        can_op(1, 2'b11, 7'd40, 16'hFFFF, rd);
        cpu_check(7'd40, "R11");

        // random mixed traffic
        for (int n = 0; n < 600; n++) begin
            int unsigned kind = $urandom % 10;
            logic [6:0]  a    = 7'($urandom);
            logic [1:0]  be   = 2'($urandom);
            logic [15:0] d    = 16'($urandom);
            if (kind < 3)      cpu_op(1, be, a, d, rd);
            else if (kind < 5) can_op(1, be, a, d, rd);
            else if (kind < 7) cpu_check(a, read_tag(a));
            else if (kind < 9) begin
                can_op(0, 2'b11, a, 16'h0, rd);
                check(rd == exp_read(a), read_tag(a), rd, exp_read(a));
            end else busy_op($urandom % 2 == 0, 4'($urandom % 16), 1'b1, 4'($urandom % 15));
        end

        finished = 1;
        finish_run();
    end
endmodule